// File: doc/BRIEF.md
# Satellite Equipment Control Message Transmitter

This block drives one output line whose high level keys an external 22 kHz tone generator, so that a host can send control messages to outdoor satellite equipment (switches, positioners, converters). The host places up to `MAX_BYTES` message bytes on a flat input bus, sets the byte count, chooses an optional trailing burst and pulses `start`. The block then frames the message with silent gaps, sends every byte as nine pulse-width-coded symbols (eight data bits, most significant first, then an odd-parity bit), appends the selected burst and reports completion with a one-cycle `done` pulse.

All durations are whole multiples of a one-microsecond tick obtained by dividing the clock (`CLK_FREQ / 1_000_000` cycles per tick). The divider restarts while the block is idle, so every segment of the waveform lasts an exact number of clock cycles measured from the accepted start. Between messages the line follows the static `tone_en` input, which gives a continuous-tone mode. Symbol and gap lengths are parameters in microseconds.

The controller is a single state machine with states IDLE, LEAD (leading silence), MARK (high part of a symbol), SPACE (low part of a symbol), TRAIL (trailing silence), BURST_A (unbroken tone burst) and HOLDOFF (silence after a burst). Transitions: IDLE to LEAD on start; LEAD to MARK when bytes remain, else to TRAIL; MARK to SPACE; SPACE to MARK for the next bit or next byte, to TRAIL after the last message bit, to HOLDOFF after the last burst-byte bit; TRAIL to BURST_A for burst A, to MARK for burst B, to IDLE for no burst; BURST_A to HOLDOFF; HOLDOFF to IDLE. Every state change other than leaving IDLE happens on a tick when the segment timer expires.

Top module: `sec_cmd_tx`

## Requirements
- R1: A 1 bit is sent as `T_SHORT_US` ticks high then `T_LONG_US` ticks low; a 0 bit as `T_LONG_US` ticks high then `T_SHORT_US` ticks low.
- R2: Byte k of the message is `msg_bytes[8k+7:8k]`, byte 0 first; each byte goes out most significant bit first, followed by one parity bit that makes the number of ones among the nine symbols odd.
- R3: The line is low for exactly `T_GAP_US` ticks before the first byte and again for `T_GAP_US` ticks after the last byte.
- R4: With `burst_sel` = 2'b01 the trailing gap is followed by a single high period of `T_BURST_US` ticks, then `T_HOLD_US` ticks low while still busy.
- R5: With `burst_sel` = 2'b10 the trailing gap is followed by the byte 0xFF with its parity bit (1), coded as in R1, then `T_HOLD_US` ticks low while still busy.
- R6: With `burst_sel` = 2'b00 or 2'b11 the message ends after the trailing gap; at the end `busy` falls and `done` is high for exactly one cycle.
- R7: A byte count of zero is legal: only the two gaps and the selected burst are sent.
- R8: A `start` pulse while `busy` is high is ignored; the waveform in progress and its parameters are unchanged.
- R9: While idle, `line_out` equals the value `tone_en` had one cycle earlier; while busy, `tone_en` has no effect on `line_out`.
- R10: One tick is `CLK_FREQ / 1_000_000` clock cycles and the tick phase restarts at the accepted start, so a segment of n ticks lasts exactly n times that many cycles, and `line_out` falls in the cycle after `start` is seen.
- R11: A byte count larger than `MAX_BYTES` is treated as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to send; sampled only when idle |
| msg_len | input | $clog2(MAX_BYTES+1) | Number of message bytes |
| msg_bytes | input | MAX_BYTES*8 | Message bytes, byte 0 in the low 8 bits |
| burst_sel | input | 2 | 00 none, 01 tone burst, 10 0xFF byte burst, 11 none |
| tone_en | input | 1 | Continuous-tone level used while idle |
| line_out | output | 1 | Tone gate line, high keys the carrier |
| busy | output | 1 | High from the cycle after an accepted start until the end |
| done | output | 1 | One-cycle pulse at the end of a transmission |

## Verification
The assertions assume that `msg_len`, `msg_bytes` and `burst_sel` are only meaningful in the cycle `start` is sampled while idle, and that `tone_en` may change at any time; they take no position on the values held on the bus during a transmission. The stimulus therefore changes the message inputs, pulses `start` and raises `tone_en` in the middle of a transmission to show those changes have no effect, and drives all inputs on the falling edge so each is stable across the sampling edge. Expected waveforms are built from segment lengths in ticks and compared with the line on every cycle.

// File: rtl/sec_pkg.sv
package sec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_SPACE,
        ST_TRAIL,
        ST_BURST_A,
        ST_HOLDOFF
    } tx_state_e;

    typedef enum logic [1:0] {
        BURST_NONE = 2'b00,
        BURST_TONE = 2'b01,
        BURST_BYTE = 2'b10,
        BURST_RSVD = 2'b11
    } burst_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_period_check
            // R10: with a real divider two ticks never sit in adjacent cycles
            p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sec_seg_timer.sv
module sec_seg_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = tick && !restart && ((cnt_q + W'(1)) == len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: a running segment never counts past its own length
    p_cnt_in_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && len != '0) |-> (cnt_q < len));

endmodule

// File: rtl/sec_bit_ser.sv
module sec_bit_ser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  logic       advance,
    output logic       cur_bit,
    output logic       last_bit
);
    logic [8:0] sh_q;
    logic [3:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= {byte_in, ~^byte_in};
            idx_q <= '0;
        end else if (advance) begin
            sh_q  <= {sh_q[7:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sh_q[8];
    assign last_bit = (idx_q == 4'd8);

    // R2: nine symbols per byte, never a tenth
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= 4'd8);
    p_no_step_past_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |-> !last_bit);

endmodule

// File: rtl/sec_cmd_tx.sv
module sec_cmd_tx #(
    parameter int unsigned CLK_FREQ   = 50_000_000,
    parameter int unsigned MAX_BYTES  = 8,
    parameter int unsigned T_SHORT_US = 500,
    parameter int unsigned T_LONG_US  = 1000,
    parameter int unsigned T_GAP_US   = 16000,
    parameter int unsigned T_BURST_US = 12500,
    parameter int unsigned T_HOLD_US  = 20000,
    localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LEN_W-1:0]       msg_len,
    input  logic [MAX_BYTES*8-1:0] msg_bytes,
    input  logic [1:0]             burst_sel,
    input  logic                   tone_en,
    output logic                   line_out,
    output logic                   busy,
    output logic                   done
);
    import sec_pkg::*;

    localparam int unsigned TICK_DIV = (CLK_FREQ >= 2_000_000) ? CLK_FREQ / 1_000_000 : 1;
    localparam int unsigned IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int unsigned T_MAX    = max2(max2(max2(T_SHORT_US, T_LONG_US), max2(T_GAP_US, T_BURST_US)), T_HOLD_US);
    localparam int unsigned TW       = $clog2(T_MAX + 1);

    tx_state_e state_q, state_d;
    burst_e    burst_q;
    logic [MAX_BYTES-1:0][7:0] data_q;
    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] byte_idx_q;
    logic             in_burst_q;
    logic             line_q, done_q;

    logic             tick, expire;
    logic [TW-1:0]    seg_len;
    logic             ser_load, ser_adv, cur_bit, last_bit;
    logic [7:0]       ser_byte;
    logic             accept, finish, set_burst, more_bytes;
    logic [LEN_W-1:0] len_clamped;
    logic             line_d;

    assign len_clamped = (msg_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : msg_len;
    assign more_bytes  = (byte_idx_q < count_q);

    sec_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_IDLE),
        .tick  (tick)
    );

    sec_seg_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_IDLE),
        .tick    (tick),
        .len     (seg_len),
        .expire  (expire)
    );

    sec_bit_ser u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .byte_in  (ser_byte),
        .advance  (ser_adv),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    // Segment length for the state being held
    always_comb begin
        unique case (state_q)
            ST_LEAD, ST_TRAIL: seg_len = TW'(T_GAP_US);
            ST_MARK:           seg_len = cur_bit ? TW'(T_SHORT_US) : TW'(T_LONG_US);
            ST_SPACE:          seg_len = cur_bit ? TW'(T_LONG_US)  : TW'(T_SHORT_US);
            ST_BURST_A:        seg_len = TW'(T_BURST_US);
            ST_HOLDOFF:        seg_len = TW'(T_HOLD_US);
            default:           seg_len = TW'(T_GAP_US);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        ser_load  = 1'b0;
        ser_adv   = 1'b0;
        ser_byte  = data_q[byte_idx_q[IDX_W-1:0]];
        accept    = 1'b0;
        finish    = 1'b0;
        set_burst = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (expire) begin
                    if (more_bytes) begin
                        ser_load = 1'b1;
                        state_d  = ST_MARK;
                    end else begin
                        state_d  = ST_TRAIL;
                    end
                end
            end
            ST_MARK: begin
                if (expire) state_d = ST_SPACE;
            end
            ST_SPACE: begin
                if (expire) begin
                    if (!last_bit) begin
                        ser_adv = 1'b1;
                        state_d = ST_MARK;
                    end else if (in_burst_q) begin
                        state_d = ST_HOLDOFF;
                    end else if (more_bytes) begin
                        ser_load = 1'b1;
                        state_d  = ST_MARK;
                    end else begin
                        state_d  = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (expire) begin
                    unique case (burst_q)
                        BURST_TONE: state_d = ST_BURST_A;
                        BURST_BYTE: begin
                            ser_load  = 1'b1;
                            ser_byte  = 8'hFF;
                            set_burst = 1'b1;
                            state_d   = ST_MARK;
                        end
                        default: begin
                            finish  = 1'b1;
                            state_d = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_BURST_A: begin
                if (expire) state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (expire) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and message context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            data_q     <= '0;
            count_q    <= '0;
            byte_idx_q <= '0;
            burst_q    <= BURST_NONE;
            in_burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                data_q     <= msg_bytes;
                count_q    <= len_clamped;
                byte_idx_q <= '0;
                burst_q    <= burst_e'(burst_sel);
                in_burst_q <= 1'b0;
            end else if (set_burst) begin
                in_burst_q <= 1'b1;
            end else if (ser_load) begin
                byte_idx_q <= byte_idx_q + 1'b1;
            end
        end
    end

    // Output register: level follows the state being entered
    always_comb begin
        line_d = (state_d == ST_MARK) || (state_d == ST_BURST_A) ||
                 ((state_d == ST_IDLE) && tone_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            line_q <= line_d;
            done_q <= finish;
        end
    end

    assign line_out = line_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

    // R3: silent segments keep the line low
    p_gaps_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD || state_q == ST_TRAIL || state_q == ST_HOLDOFF) |-> !line_out);
    // R6: completion is a single-cycle pulse that ends busy
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R8: a start while busy leaves the latched request untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(count_q) && $stable(burst_q)));
    // R9: idle line tracks the tone request, busy line only high in keyed states
    p_tone_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (line_out == $past(tone_en)));
    p_busy_high_keyed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_out) |-> (state_q == ST_MARK || state_q == ST_BURST_A));
    // R11: stored byte count never exceeds the buffer
    p_len_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LEN_W'(MAX_BYTES));

endmodule

// File: tb/sim_sec_cmd_tx.sv
module sim_sec_cmd_tx;
    localparam int DIV = 3;
    localparam int MB  = 4;
    localparam int LW  = $clog2(MB + 1);
    localparam int TS  = 2;
    localparam int TL  = 4;
    localparam int TG  = 6;
    localparam int TB  = 5;
    localparam int TH  = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [LW-1:0]   msg_len = '0;
    logic [MB*8-1:0] msg_bytes = '0;
    logic [1:0]      burst_sel = 2'b00;
    logic            tone_en = 1'b0;
    logic            line_out, busy, done;

    sec_cmd_tx #(
        .CLK_FREQ(DIV * 1_000_000), .MAX_BYTES(MB),
        .T_SHORT_US(TS), .T_LONG_US(TL), .T_GAP_US(TG),
        .T_BURST_US(TB), .T_HOLD_US(TH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
        .msg_bytes(msg_bytes), .burst_sel(burst_sel), .tone_en(tone_en),
        .line_out(line_out), .busy(busy), .done(done)
    );

    int    vectors = 0;
    int    misses  = 0;
    bit    finished = 1'b0;
    int    nseg;
    int    seg_lvl [0:127];
    int    seg_len [0:127];
    string seg_tag [0:127];

    task automatic check(string tag, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic add_seg(int lvl, int ticks, string tag);
        seg_lvl[nseg] = lvl;
        seg_len[nseg] = ticks;
        seg_tag[nseg] = tag;
        nseg++;
    endtask

    task automatic add_byte(logic [7:0] b, string tag);
        int ones = 0;
        for (int i = 7; i >= 0; i--) begin
            ones += b[i];
            add_seg(1, b[i] ? TS : TL, tag);
            add_seg(0, b[i] ? TL : TS, tag);
        end
        // parity makes the nine-symbol count odd
        if ((ones % 2) == 0) begin
            add_seg(1, TS, tag);
            add_seg(0, TL, tag);
        end else begin
            add_seg(1, TL, tag);
            add_seg(0, TS, tag);
        end
    endtask

    task automatic run_msg(int len, logic [MB*8-1:0] data, logic [1:0] sel, bit disturb);
        int    eff = (len > MB) ? MB : len;
        int    k = 0;
        string extra = "";
        if (len == 0) extra = {extra, " R7"};
        if (len > MB) extra = {extra, " R11"};
        if (disturb)  extra = {extra, " R8 R9"};
        nseg = 0;
        add_seg(0, TG, {"R3 R10", extra});
        for (int b = 0; b < eff; b++) add_byte(data[b*8 +: 8], {"R1 R2 R10", extra});
        add_seg(0, TG, {"R3 R10", extra});
        if (sel == 2'b01) begin
            add_seg(1, TB, {"R4", extra});
            add_seg(0, TH, {"R4", extra});
        end else if (sel == 2'b10) begin
            add_byte(8'hFF, {"R5", extra});
            add_seg(0, TH, {"R5", extra});
        end
        @(negedge clk);
        msg_len   = LW'(len);
        msg_bytes = data;
        burst_sel = sel;
        start     = 1'b1;
        for (int s = 0; s < nseg; s++) begin
            for (int c = 0; c < seg_len[s] * DIV; c++) begin
                @(negedge clk);
                if (k == 0) start = 1'b0;
                check(seg_tag[s], "line", line_out, seg_lvl[s][0]);
                check(seg_tag[s], "busy", busy, 1'b1);
                check(seg_tag[s], "done", done, 1'b0);
                if (disturb && k == 7) begin
                    start     = 1'b1;
                    msg_len   = '0;
                    msg_bytes = ~data;
                    burst_sel = 2'b01;
                    tone_en   = 1'b1;
                end
                if (disturb && k == 8) start = 1'b0;
                k++;
            end
        end
        @(negedge clk);
        check("R6", "busy at end", busy, 1'b0);
        check("R6", "done at end", done, 1'b1);
        check("R9", "line at end", line_out, tone_en);
        @(negedge clk);
        check("R6", "done width", done, 1'b0);
        if (tone_en) begin
            tone_en = 1'b0;
            @(negedge clk);
            check("R9", "tone release", line_out, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [MB*8-1:0] pats [0:3];
        pats[0] = 32'hA53C_00FF;
        pats[1] = 32'h0123_4567;
        pats[2] = 32'h8001_7EFE;
        pats[3] = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        check("R6", "reset line", line_out, 1'b0);
        check("R6", "reset busy", busy, 1'b0);
        check("R6", "reset done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle continuous tone
        tone_en = 1'b1;
        @(negedge clk);
        check("R9", "idle tone on", line_out, 1'b1);
        tone_en = 1'b0;
        @(negedge clk);
        check("R9", "idle tone off", line_out, 1'b0);
        // sweep byte count and burst choice
        for (int len = 0; len <= MB + 1; len++) begin
            for (int sel = 0; sel < 4; sel++) begin
                run_msg(len, pats[(len + sel) % 4], 2'(sel), 1'b0);
            end
        end
        // extra data patterns at full length
        for (int p = 0; p < 4; p++) run_msg(MB, pats[p], 2'b00, 1'b0);
        run_msg(MB, '0, 2'b10, 1'b0);
        // R8, R9: start and tone request during a transmission
        run_msg(2, pats[1], 2'b00, 1'b1);
        run_msg(1, pats[2], 2'b01, 1'b1);
        run_msg(3, pats[3], 2'b10, 1'b1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule